// File: doc/BRIEF.md
# Bus Error Capture Unit

This block sits beside one bus interface of a system controller (a processor port, an on-chip SRAM or a PCI port). It records what went wrong there for software. Separate detection logic raises a one-cycle error strobe. With the strobe come a vector of cause bits and the attributes of the failing access: a 64-bit address, 64 bits of data, and one word of side information. That word holds parity, or PCI attribute and command. The unit keeps the first failure of a burst in a frozen snapshot, gathers every failure into a sticky cause register, and drives two level outputs toward the interrupt controller.

Software services it through a simple word-indexed register port. It reads the snapshot and the cause, and then clears the cause bits it has handled by writing zeros into them. To initialise the unit, software first clears the cause, then writes the masks as zero, then writes each mask with its enable pattern. Examples of enable patterns are 0x00A50C24 for a PCI port, or 0x000000FF when the cause width is set to 8 for a processor port. Bit 0 of both masks is locked to zero when `LOCK_LSB` is set.

Top module: `errcap_unit`

## Requirements
- R1: After reset the cause register, both masks, all snapshot words, `irq`, `serr` and `rd_valid` are zero.
- R2: An error strobe with at least one cause bit set, arriving while the cause register is all zero, loads the snapshot. Index 3 receives address[31:0], index 4 address[63:32], index 5 data[31:0], index 6 data[63:32], and index 7 the info word. The strobe's bits are also set in the cause register (index 0). A strobe with no cause bits changes nothing.
- R3: While the cause register is nonzero, the snapshot holds its value. Further strobes only OR their bits into the cause.
- R4: A write to the cause register (index 0) keeps only those set bits that are also set in the written word. Writing zero clears the register. Writing the inverse of a read value clears exactly the bits that were read.
- R5: When a strobe arrives in the same cycle as a cause write, the strobe's bits end up set.
- R6: `irq` is high exactly when (cause AND interrupt mask) is nonzero. It changes on the same clock edge as the cause register and mask, so it drops on the edge that takes a clearing write.
- R7: `serr` follows (cause AND system-error mask) with the same timing as `irq`.
- R8: Bit 0 of the interrupt mask (index 1) and of the system-error mask (index 2) always reads as 0. Writing 1 to it has no effect on `irq` or `serr`.
- R9: Mask bits other than bit 0 read back as written. For example, 0x00A50C24 reads back unchanged and 0xFFFFFFFF reads back as 0xFFFFFFFE.
- R10: A read request returns its data with `rd_valid` high one clock later. Writes to snapshot indices 3 to 7 are ignored.
- R11: Once the cause has been fully cleared, the next qualifying strobe loads a fresh snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Error strobe |
| err_src | input | 32 | Cause bits raised by this strobe |
| err_addr | input | 64 | Address of the failing access |
| err_data | input | 64 | Data of the failing access |
| err_info | input | 32 | Parity or attribute/command word |
| wr_en | input | 1 | Register write request |
| wr_idx | input | 3 | Register index for writes |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read request |
| rd_idx | input | 3 | Register index for reads |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid |
| irq | output | 1 | Summary interrupt, gated by the interrupt mask |
| serr | output | 1 | System-error request, gated by the system-error mask |

## Verification
A snapshot that reloads when it should stay frozen shows up as a wrong address, data or info word. This appears on the first read after a second strobe. A snapshot that misses a reload after a full clear shows up the same way. A cause bit that is dropped, or lost to a concurrent clear, shows one cycle later as a wrong cause readback and usually as `irq` or `serr` at the wrong level on the very next sample. A mask whose bit 0 can be set appears at once on the mask readback.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

  // Register indices on the word-addressed service port
  typedef enum logic [2:0] {
    IDX_CAUSE   = 3'd0,
    IDX_IMASK   = 3'd1,
    IDX_SMASK   = 3'd2,
    IDX_ADDR_LO = 3'd3,
    IDX_ADDR_HI = 3'd4,
    IDX_DATA_LO = 3'd5,
    IDX_DATA_HI = 3'd6,
    IDX_INFO    = 3'd7
  } reg_idx_e;

  // Snapshot words: addr lo/hi, data lo/hi, info
  localparam int SNAP_WORDS = 5;
  localparam int SNAP_BASE  = 3;

endpackage

// File: rtl/errcap_mask.sv
module errcap_mask #(
  parameter int BUS_W    = 32,
  parameter int CAUSE_W  = 32,
  parameter bit LOCK_LSB = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [BUS_W-1:0]   wdata,
  output logic [CAUSE_W-1:0] mask_d,
  output logic [CAUSE_W-1:0] mask_q
);

  generate
    if (LOCK_LSB) begin : g_lock
      logic [CAUSE_W-1:1] hi_q;
      always_ff @(posedge clk) begin
        if (rst) hi_q <= '0;
        else if (we) hi_q <= wdata[CAUSE_W-1:1];
      end
      assign mask_q = {hi_q, 1'b0};
      assign mask_d = we ? {wdata[CAUSE_W-1:1], 1'b0} : mask_q;
    end else begin : g_free
      logic [CAUSE_W-1:0] all_q;
      always_ff @(posedge clk) begin
        if (rst) all_q <= '0;
        else if (we) all_q <= wdata[CAUSE_W-1:0];
      end
      assign mask_q = all_q;
      assign mask_d = we ? wdata[CAUSE_W-1:0] : all_q;
    end
  endgenerate

endmodule

// File: rtl/errcap_cause.sv
module errcap_cause #(
  parameter int CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CAUSE_W-1:0] ev_bits,
  input  logic               clr_we,
  input  logic [CAUSE_W-1:0] clr_data,
  input  logic [CAUSE_W-1:0] imask_d,
  input  logic [CAUSE_W-1:0] smask_d,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               load_snap,
  output logic               irq_q,
  output logic               serr_q
);

  logic [CAUSE_W-1:0] cause_d;

  // Write-zero-to-clear, then new events OR in (events win a tie)
  always_comb begin
    cause_d = clr_we ? (cause_q & clr_data) : cause_q;
    cause_d = cause_d | ev_bits;
  end

  // Snapshot only loads from an idle (all-zero) cause
  assign load_snap = (|ev_bits) && (cause_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      irq_q   <= 1'b0;
      serr_q  <= 1'b0;
    end else begin
      cause_q <= cause_d;
      irq_q   <= |(cause_d & imask_d);
      serr_q  <= |(cause_d & smask_d);
    end
  end

endmodule

// File: rtl/errcap_snapshot.sv
module errcap_snapshot #(
  parameter int BUS_W = 32,
  parameter int WORDS = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [WORDS*BUS_W-1:0] src,
  output logic [WORDS*BUS_W-1:0] snap_q
);

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst) snap_q[w*BUS_W +: BUS_W] <= '0;
        else if (load) snap_q[w*BUS_W +: BUS_W] <= src[w*BUS_W +: BUS_W];
      end
    end
  endgenerate

endmodule

// File: rtl/errcap_unit.sv
module errcap_unit
  import errcap_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int CAUSE_W  = 32,
  parameter bit LOCK_LSB = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 err_valid,
  input  logic [CAUSE_W-1:0]   err_src,
  input  logic [2*BUS_W-1:0]   err_addr,
  input  logic [2*BUS_W-1:0]   err_data,
  input  logic [BUS_W-1:0]     err_info,
  input  logic                 wr_en,
  input  logic [2:0]           wr_idx,
  input  logic [BUS_W-1:0]     wr_data,
  input  logic                 rd_en,
  input  logic [2:0]           rd_idx,
  output logic [BUS_W-1:0]     rd_data,
  output logic                 rd_valid,
  output logic                 irq,
  output logic                 serr
);

  localparam int SNAP_W = SNAP_WORDS * BUS_W;

  logic [CAUSE_W-1:0] ev_bits;
  logic               wr_cause, wr_imask, wr_smask;
  logic [CAUSE_W-1:0] cause_q, imask_q, smask_q, imask_d, smask_d;
  logic               load_snap;
  logic [SNAP_W-1:0]  snap_src, snap_q;

  assign ev_bits  = err_valid ? err_src : '0;
  assign wr_cause = wr_en && (reg_idx_e'(wr_idx) == IDX_CAUSE);
  assign wr_imask = wr_en && (reg_idx_e'(wr_idx) == IDX_IMASK);
  assign wr_smask = wr_en && (reg_idx_e'(wr_idx) == IDX_SMASK);
  assign snap_src = {err_info, err_data, err_addr};

  errcap_mask #(.BUS_W(BUS_W), .CAUSE_W(CAUSE_W), .LOCK_LSB(LOCK_LSB)) u_imask (
    .clk(clk), .rst(rst), .we(wr_imask), .wdata(wr_data),
    .mask_d(imask_d), .mask_q(imask_q)
  );

  errcap_mask #(.BUS_W(BUS_W), .CAUSE_W(CAUSE_W), .LOCK_LSB(LOCK_LSB)) u_smask (
    .clk(clk), .rst(rst), .we(wr_smask), .wdata(wr_data),
    .mask_d(smask_d), .mask_q(smask_q)
  );

  errcap_cause #(.CAUSE_W(CAUSE_W)) u_cause (
    .clk(clk), .rst(rst), .ev_bits(ev_bits),
    .clr_we(wr_cause), .clr_data(wr_data[CAUSE_W-1:0]),
    .imask_d(imask_d), .smask_d(smask_d),
    .cause_q(cause_q), .load_snap(load_snap),
    .irq_q(irq), .serr_q(serr)
  );

  errcap_snapshot #(.BUS_W(BUS_W), .WORDS(SNAP_WORDS)) u_snap (
    .clk(clk), .rst(rst), .load(load_snap), .src(snap_src), .snap_q(snap_q)
  );

  // Zero-extend narrow registers to the bus width
  logic [BUS_W-1:0] cause_w, imask_w, smask_w, rd_word;
  always_comb begin
    cause_w = '0; cause_w[CAUSE_W-1:0] = cause_q;
    imask_w = '0; imask_w[CAUSE_W-1:0] = imask_q;
    smask_w = '0; smask_w[CAUSE_W-1:0] = smask_q;
  end

  always_comb begin
    case (reg_idx_e'(rd_idx))
      IDX_CAUSE: rd_word = cause_w;
      IDX_IMASK: rd_word = imask_w;
      IDX_SMASK: rd_word = smask_w;
      default:   rd_word = snap_q[(int'(rd_idx) - SNAP_BASE)*BUS_W +: BUS_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_word;
    end
  end

endmodule

// File: rtl/errcap_chk.sv
module errcap_chk #(
  parameter int BUS_W    = 32,
  parameter int CAUSE_W  = 32,
  parameter bit LOCK_LSB = 1'b1,
  parameter int SNAP_W   = 160
) (
  input logic               clk,
  input logic               rst,
  input logic               err_valid,
  input logic [CAUSE_W-1:0] err_src,
  input logic               wr_en,
  input logic [2:0]         wr_idx,
  input logic [BUS_W-1:0]   wr_data,
  input logic               rd_en,
  input logic [2:0]         rd_idx,
  input logic [BUS_W-1:0]   rd_data,
  input logic               rd_valid,
  input logic               irq,
  input logic               serr,
  input logic [CAUSE_W-1:0] cause_q,
  input logic [CAUSE_W-1:0] imask_q,
  input logic [CAUSE_W-1:0] smask_q,
  input logic [SNAP_W-1:0]  snap_q
);

  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(cause_q & imask_q)));

  // R7
  serr_level_chk: assert property (@(posedge clk) disable iff (rst)
    serr == (|(cause_q & smask_q)));

  // R3
  snap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_q != '0) |=> $stable(snap_q));

  // R5
  event_sets_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> ((cause_q & $past(err_src)) == $past(err_src)));

  // R4
  w0c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 3'd0 && !err_valid) |=>
      (cause_q == ($past(cause_q) & $past(wr_data[CAUSE_W-1:0]))));

  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  generate
    if (LOCK_LSB) begin : g_lsb
      // R8
      mask_lsb_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rd_idx == 3'd1 || rd_idx == 3'd2)) |=> !rd_data[0]);
    end
  endgenerate

endmodule

bind errcap_unit errcap_chk #(
  .BUS_W(BUS_W), .CAUSE_W(CAUSE_W), .LOCK_LSB(LOCK_LSB), .SNAP_W(SNAP_W)
) u_chk (
  .clk(clk), .rst(rst), .err_valid(err_valid), .err_src(err_src),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
  .irq(irq), .serr(serr), .cause_q(cause_q), .imask_q(imask_q),
  .smask_q(smask_q), .snap_q(snap_q)
);

// File: tb/tb_errcap_unit.sv
module tb_errcap_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        err_valid = 1'b0;
  logic [31:0] err_src = '0;
  logic [63:0] err_addr = '0;
  logic [63:0] err_data = '0;
  logic [31:0] err_info = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        irq, serr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  errcap_unit dut (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_src(err_src),
    .err_addr(err_addr), .err_data(err_data), .err_info(err_info),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq(irq), .serr(serr)
  );

  // Monitor: pop and compare each returned read
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected rd_valid, got %h expected none", rd_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rd_data !== e.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", e.tag, rd_data, e.exp);
        end
      end
    end
  end

  task automatic rd(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx;
    sb.push_back('{exp, tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ev(input logic [31:0] src, input logic [63:0] a, input logic [63:0] d,
                    input logic [31:0] inf, input bit clr, input logic [31:0] cv);
    @(negedge clk);
    err_valid = 1'b1; err_src = src; err_addr = a; err_data = d; err_info = inf;
    if (clr) begin wr_en = 1'b1; wr_idx = 3'd0; wr_data = cv; end
    @(negedge clk);
    err_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 50000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(irq, 1'b0, "R1 irq");
    chk(serr, 1'b0, "R1 serr");
    chk(rd_valid, 1'b0, "R1 rd_valid");
    rd(3'd0, 32'h0, "R1 cause");
    rd(3'd1, 32'h0, "R1 imask");
    rd(3'd3, 32'h0, "R1 addr_lo");

    // Init sequence, R8 / R9 mask behaviour
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd1, 32'h0000_0001);
    rd(3'd1, 32'h0, "R8 imask bit0");
    wr(3'd1, 32'h00A5_0C24);
    rd(3'd1, 32'h00A5_0C24, "R9 imask");
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, 32'hFFFF_FFFE, "R9 smask");

    // R2 first capture
    ev(32'h4, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 32'hC0DE_0001, 1'b0, '0);
    chk(irq, 1'b1, "R6 irq set");
    chk(serr, 1'b1, "R7 serr set");
    rd(3'd0, 32'h4, "R2 cause");
    rd(3'd3, 32'h3333_4444, "R2 addr_lo");
    rd(3'd4, 32'h1111_2222, "R2 addr_hi");
    rd(3'd5, 32'hCCCC_DDDD, "R2 data_lo");
    rd(3'd6, 32'hAAAA_BBBB, "R2 data_hi");
    rd(3'd7, 32'hC0DE_0001, "R2 info");

    // R3 frozen snapshot
    ev(32'h800, 64'h9999_8888_7777_6666, 64'h0, 32'h0, 1'b0, '0);
    rd(3'd0, 32'h804, "R3 cause accum");
    rd(3'd3, 32'h3333_4444, "R3 addr_lo frozen");

    // R10 snapshot write ignored
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd3, 32'h3333_4444, "R10 snap write ignored");

    // R4 inverse-of-read clear
    wr(3'd0, ~32'h800);
    rd(3'd0, 32'h4, "R4 partial clear");
    chk(irq, 1'b1, "R6 irq still set");

    // R7 serr follows new mask; R8 mask bit0 cannot gate
    wr(3'd2, 32'h0000_0011);
    chk(serr, 1'b0, "R7 serr masked");
    rd(3'd2, 32'h10, "R8 smask bit0");

    // R6 drop after full clear
    wr(3'd0, 32'h0);
    chk(irq, 1'b0, "R6 irq drop");
    rd(3'd0, 32'h0, "R4 full clear");

    // R11 reload after clear; bit1 masked
    ev(32'h2, 64'h0000_00F0_1234_5678, 64'h0, 32'h42, 1'b0, '0);
    chk(irq, 1'b0, "R6 masked source");
    rd(3'd3, 32'h1234_5678, "R11 addr_lo reload");
    rd(3'd7, 32'h42, "R11 info reload");

    // R5 event vs concurrent clear
    ev(32'h20, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h0, 1'b1, 32'h0);
    rd(3'd0, 32'h20, "R5 event wins");
    chk(irq, 1'b1, "R5 irq");
    rd(3'd3, 32'h1234_5678, "R3 no load while busy");

    // R2 zero-bit strobe changes nothing
    wr(3'd0, 32'h0);
    ev(32'h0, 64'h0000_0000_0000_0BAD, 64'h0, 32'h0, 1'b0, '0);
    rd(3'd0, 32'h0, "R2 empty strobe cause");
    rd(3'd3, 32'h1234_5678, "R2 empty strobe snap");

    // R7 / R11 serr-only source
    ev(32'h10, 64'h0000_0000_0000_BEEF, 64'h0, 32'h0, 1'b0, '0);
    chk(serr, 1'b1, "R7 serr only");
    chk(irq, 1'b0, "R6 irq stays low");
    rd(3'd3, 32'h0000_BEEF, "R11 second reload");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: got %0d pending reads expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule